// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block holds an eight-bit instrument status byte and an eight-bit enable mask that decides which status conditions may ask the controller for service. Every clock it samples three conditions: the error queue holds an entry, the output buffer has a message ready, and an event status word together with its enable word. From these it builds the status byte. It derives a summary bit from the enabled conditions. It raises a service request when an enabled condition turns from false to true.

A host uses a small register port to write and read the enable mask and to query the status byte. A separate poll strobe also returns the status byte, and it is the only way to drop a pending request. The bus physical layer, the error queue storage and the command parser sit outside this block.

Top module: `status_srq`

## Requirements
- R1: Status byte bits 0, 1, 3 and 7 always read 0.
- R2: Status bit 2 equals `err_pending` as sampled at the previous clock edge.
- R3: Status bit 4 equals `msg_ready` as sampled at the previous clock edge.
- R4: Status bit 5 equals the OR of (`evt_status` AND `evt_enable`) as sampled at the previous clock edge.
- R5: Status bit 6 is 1 exactly when some other status bit is 1 and its mask bit is 1. Mask bit 6 never contributes to it.
- R6: The mask resets to 0x00. A write (`reg_wr`) stores all eight bits of `reg_wdata`, including bit 6. With `reg_addr`=1 and no poll, `reg_rdata` returns the mask. With `reg_addr`=0, `reg_rdata` returns the status byte.
- R7: `srq` rises in the same cycle that an enabled status bit (mask bit set, bit 6 excluded) changes from 0 to 1.
- R8: A status bit that is already 1 when its mask bit is set raises no request. A disabled bit rising raises no request, and neither does mask bit 6.
- R9: `srq` stays high until a cycle with `poll_rd`=1. A query read does not clear it. While `poll_rd`=1, `reg_rdata` returns the status byte whatever `reg_addr` is.
- R10: If a new enabled rise and `poll_rd` occur in the same cycle, `srq` is 1 afterwards. Two enabled bits rising together give one request.
- R11: After reset, the status byte is 0x00 and `srq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pending | input | 1 | Error queue holds at least one entry |
| msg_ready | input | 1 | Readable message waiting in output buffer |
| evt_status | input | 8 | Event status word |
| evt_enable | input | 8 | Enable word for the event status |
| reg_addr | input | 1 | 0 = status byte, 1 = enable mask |
| reg_wr | input | 1 | Write strobe for the enable mask |
| reg_wdata | input | 8 | Mask write data |
| poll_rd | input | 1 | Serial-poll read strobe; clears the request |
| reg_rdata | output | 8 | Read data |
| srq | output | 1 | Service request level |

## Verification
A stale copy of the previous status bits shows up as a request that is missing or extra. This appears on `srq` in the same cycle as the status change, one clock after the input moves. A wrong mask register or a wrong bit-6 handling shows up in the summary bit of the status byte as soon as the mask is read or a status bit is set. A clear with the wrong priority shows as `srq` low right after a poll that coincided with a new rise.

// File: rtl/status_srq.sv
module status_srq #(
  parameter int W       = 8,
  parameter int EW      = 8,
  parameter int ERR_BIT = 2,
  parameter int MAV_BIT = 4,
  parameter int ESB_BIT = 5,
  parameter int MSS_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_pending,
  input  logic          msg_ready,
  input  logic [EW-1:0] evt_status,
  input  logic [EW-1:0] evt_enable,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          poll_rd,
  output logic [W-1:0]  reg_rdata,
  output logic          srq
);
  localparam logic [W-1:0] MSS_ONE = W'(1) << MSS_BIT;

  logic [W-1:0] base_q, base_d, mask_q, live_mask, rise, stb;
  logic         mss;

  always_comb begin
    base_d          = '0;
    base_d[ERR_BIT] = err_pending;
    base_d[MAV_BIT] = msg_ready;
    base_d[ESB_BIT] = |(evt_status & evt_enable);
  end

  assign live_mask = mask_q & ~MSS_ONE;
  assign rise      = base_d & ~base_q & live_mask;
  assign mss       = |(base_q & live_mask);
  assign stb       = base_q | (mss ? MSS_ONE : '0);
  assign reg_rdata = (reg_addr && !poll_rd) ? mask_q : stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      srq    <= 1'b0;
    end else begin
      base_q <= base_d;
      if (reg_wr) mask_q <= reg_wdata;
      if (|rise)        srq <= 1'b1;
      else if (poll_rd) srq <= 1'b0;
    end
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb[0] == 1'b0) && (stb[1] == 1'b0) && (stb[3] == 1'b0) && (stb[7] == 1'b0)); // R1
  AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    err_pending |=> stb[ERR_BIT]); // R2
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> mask_q == $past(reg_wdata)); // R6
  AST_SRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srq) |-> stb[MSS_BIT]); // R7
  AST_SRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (srq && !poll_rd) |=> srq); // R9
endmodule

// File: tb/status_srq_tb.sv
module status_srq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic err_pending = 0, msg_ready = 0, reg_addr = 0, reg_wr = 0, poll_rd = 0;
  logic [7:0] evt_status = 0, evt_enable = 0, reg_wdata = 0, reg_rdata;
  logic srq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  status_srq u_dut (.clk, .rst_n, .err_pending, .msg_ready, .evt_status, .evt_enable,
    .reg_addr, .reg_wr, .reg_wdata, .poll_rd, .reg_rdata, .srq);

  // {err, msg, evt_status, evt_enable, poll, exp_stb, exp_srq}, mask = 0x34
  localparam logic [27:0] VEC [10] = '{
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h44, 1'b1},
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 8'h44, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 8'h50, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 8'h50, 1'b0},
    {1'b0, 1'b0, 8'h81, 8'h01, 1'b0, 8'h60, 1'b1},
    {1'b0, 1'b0, 8'h81, 8'h00, 1'b0, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h02, 8'h04, 1'b0, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 8'h54, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 8'h54, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk); reg_wr = 1; reg_wdata = m;
    tick(); @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R11 status", reg_rdata, 8'h00);
    check("R11 srq", {7'b0, srq}, 8'h00);
    reg_addr = 1; #1;
    check("R6 reset mask", reg_rdata, 8'h00);

    // mask 0: a rising bit raises no request
    @(negedge clk); reg_addr = 0; err_pending = 1; tick();
    check("R2 err bit", reg_rdata, 8'h04);
    check("R8 disabled", {7'b0, srq}, 8'h00);
    // enabling a bit that is already set: summary appears, no request
    write_mask(8'h04); #1;
    check("R5 summary", reg_rdata, 8'h44);
    check("R8 late enable", {7'b0, srq}, 8'h00);
    // mask bit 6 only
    write_mask(8'h40);
    err_pending = 0; tick();
    @(negedge clk); err_pending = 1; tick();
    check("R5 bit6 ignored", reg_rdata, 8'h04);
    check("R8 bit6 mask", {7'b0, srq}, 8'h00);
    @(negedge clk); reg_addr = 1; #1;
    check("R6 bit6 stored", reg_rdata, 8'h40);
    write_mask(8'hFF); reg_addr = 1; #1;
    check("R6 readback", reg_rdata, 8'hFF);
    reg_addr = 0; err_pending = 0; tick();
    write_mask(8'h34);

    foreach (VEC[i]) begin
      @(negedge clk);
      err_pending = VEC[i][27]; msg_ready = VEC[i][26];
      evt_status = VEC[i][25:18]; evt_enable = VEC[i][17:10]; poll_rd = VEC[i][9];
      tick();
      check($sformatf("R7/R9/R10 stb vec%0d (R1 R2 R3 R4 R5)", i), reg_rdata, VEC[i][8:1]);
      check($sformatf("R7/R9/R10 srq vec%0d", i), {7'b0, srq}, {7'b0, VEC[i][0]});
    end

    // request held across a query read, poll read returns status byte
    @(negedge clk); poll_rd = 0; err_pending = 0; msg_ready = 0; tick();
    @(negedge clk); msg_ready = 1; tick();
    check("R3 msg bit", reg_rdata, 8'h50);
    @(negedge clk); reg_addr = 0; tick(); tick();
    check("R9 query keeps srq", {7'b0, srq}, 8'h01);
    @(negedge clk); reg_addr = 1; poll_rd = 1; #1;
    check("R9 poll data", reg_rdata, 8'h50);
    tick();
    check("R9 poll clears", {7'b0, srq}, 8'h00);
    @(negedge clk); poll_rd = 0; #1;
    check("R1 unused bits", reg_rdata & 8'h8B, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule